// File: doc/BRIEF.md
# Flag-Producing Arithmetic Logic Unit

This block is the integer execute stage of a small datapath. It takes two operands of a configurable width, a carry input and a four-bit function code. It returns a result and four condition flags: zero, negative, carry and signed overflow. Three parallel paths compute every cycle: an adder path, a bitwise logic path and a one-position shifter path. An output selector picks one of them according to the function code. Subtraction, borrow-chained subtraction and decrement all use the one adder. They invert or replace the second adder input and steer the adder's carry input; there is no second subtractor.

The arithmetic core is purely combinational. A thin output register samples its result and flags on every rising clock edge, so values are stable for checking and for a downstream status register. The carry input lets software chain the carry or borrow of one word into the next when it adds or subtracts values wider than the datapath.

Top module: `alu_flagged`

## Requirements
- R1: A synchronous active-high reset clears the result and all four flags to 0. Outside reset, the outputs present the function of the inputs sampled at the previous rising edge (latency of one clock).
- R2: Code 0000 (ADD) gives A+B and code 0001 (ADC) gives A+B+carry_in, both modulo 2^W. The carry flag is the carry out of the top bit.
- R3: Code 0110 (SUB) computes A+~B+1 and code 0111 (SBC) computes A+~B+carry_in, both on the shared adder. Carry set means no borrow. With A=5 and B=3, SUB gives 2 with C=1, Z=0 and N=0.
- R4: Code 1000 (INC) gives A+1, with C set only when A is all ones. Code 1001 (DEC) gives A-1, with C set unless A is zero.
- R5: For the six adder codes, V is set exactly when the true signed result of the two's-complement operation lies outside the W-bit signed range. Every other code clears V.
- R6: For every code, Z is 1 exactly when all result bits are 0, and N equals the top result bit.
- R7: Codes 0010 AND, 0011 OR, 0100 XOR and 0101 NOT(A) work bitwise on all W bits and clear C and V. For example, AND of the upper-half-ones and lower-half-ones patterns gives 0 with Z=1.
- R8: Codes 1010 (logical left), 1011 (logical right) and 1100 (arithmetic right, sign bit kept) shift A by one position. C takes the bit shifted out and V is cleared.
- R9: Codes 1101 (rotate left) and 1110 (rotate right) rotate A by one position. C takes the bit that wrapped around and V is cleared.
- R10: The unused code 1111 yields a zero result with Z=1 and N, C and V cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock of the output register |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| carry_in | input | 1 | Carry or no-borrow from a previous word |
| func | input | 4 | Function code |
| result_q | output | W | Registered result |
| flag_z | output | 1 | Registered zero flag |
| flag_n | output | 1 | Registered negative flag |
| flag_c | output | 1 | Registered carry / no-borrow / shifted-out bit |
| flag_v | output | 1 | Registered signed overflow flag |

## Verification
Every result and flag is due exactly one rising edge after its operands and function code are presented. Nothing in the block spans more than that single register stage. The bench drives each vector on a falling edge and computes its expected outputs from integer arithmetic on signed and unsigned values. It holds them in a queue and compares them at the very next falling edge, half a period after the register has updated. This keeps every comparison on the one cycle where that vector's answer is due and clear of the sampling edge.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int FUNC_W = 4;

    typedef enum logic [FUNC_W-1:0] {
        OP_ADD = 4'b0000,
        OP_ADC = 4'b0001,
        OP_AND = 4'b0010,
        OP_OR  = 4'b0011,
        OP_XOR = 4'b0100,
        OP_NOT = 4'b0101,
        OP_SUB = 4'b0110,
        OP_SBC = 4'b0111,
        OP_INC = 4'b1000,
        OP_DEC = 4'b1001,
        OP_LSL = 4'b1010,
        OP_LSR = 4'b1011,
        OP_ASR = 4'b1100,
        OP_ROL = 4'b1101,
        OP_ROR = 4'b1110,
        OP_NOP = 4'b1111
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_ARITH,
        CLS_LOGIC,
        CLS_SHIFT,
        CLS_NONE
    } op_class_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } alu_flags_t;

    function automatic op_class_e class_of(input alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_INC, OP_DEC: class_of = CLS_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_NOT:                  class_of = CLS_LOGIC;
            OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR:         class_of = CLS_SHIFT;
            default:                                        class_of = CLS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  alu_op_e      op,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] addend;
    logic         carry_seed;
    logic [W:0]   wide;

    // Second adder input and carry seed are steered; the adder itself is shared.
    always_comb begin
        case (op)
            OP_ADD: begin addend = b;         carry_seed = 1'b0; end
            OP_ADC: begin addend = b;         carry_seed = cin;  end
            OP_SUB: begin addend = ~b;        carry_seed = 1'b1; end
            OP_SBC: begin addend = ~b;        carry_seed = cin;  end
            OP_INC: begin addend = '0;        carry_seed = 1'b1; end
            OP_DEC: begin addend = '1;        carry_seed = 1'b0; end
            default: begin addend = '0;       carry_seed = 1'b0; end
        endcase
    end

    assign wide = {1'b0, a} + {1'b0, addend} + {{W{1'b0}}, carry_seed};
    assign sum  = wide[W-1:0];
    assign cout = wide[W];
    // Operands of equal sign producing a sum of the other sign.
    assign ovf  = (a[MSB] == addend[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] res
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            always_comb begin
                case (op)
                    OP_AND:  res[i] = a[i] & b[i];
                    OP_OR:   res[i] = a[i] | b[i];
                    OP_XOR:  res[i] = a[i] ^ b[i];
                    OP_NOT:  res[i] = ~a[i];
                    default: res[i] = 1'b0;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic         out_bit
);
    localparam int MSB = W - 1;

    always_comb begin
        case (op)
            OP_LSL: begin res = {a[MSB-1:0], 1'b0};   out_bit = a[MSB]; end
            OP_LSR: begin res = {1'b0, a[MSB:1]};     out_bit = a[0];   end
            OP_ASR: begin res = {a[MSB], a[MSB:1]};   out_bit = a[0];   end
            OP_ROL: begin res = {a[MSB-1:0], a[MSB]}; out_bit = a[MSB]; end
            OP_ROR: begin res = {a[0], a[MSB:1]};     out_bit = a[0];   end
            default: begin res = '0;                  out_bit = 1'b0;   end
        endcase
    end

endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         carry_in,
    input  logic [3:0]   func,
    output logic [W-1:0] result_q,
    output logic         flag_z,
    output logic         flag_n,
    output logic         flag_c,
    output logic         flag_v
);
    localparam int MSB = W - 1;

    alu_op_e      op;
    op_class_e    cls;
    logic [W-1:0] arith_res, logic_res, shift_res, sel_res;
    logic         arith_c, arith_v, shift_c;
    alu_flags_t   nxt_flags, flags_q;

    assign op  = alu_op_e'(func);
    assign cls = class_of(op);

    alu_arith #(.W(W)) u_arith (
        .a(op_a), .b(op_b), .cin(carry_in), .op(op),
        .sum(arith_res), .cout(arith_c), .ovf(arith_v)
    );

    alu_logic #(.W(W)) u_logic (
        .a(op_a), .b(op_b), .op(op), .res(logic_res)
    );

    alu_shift #(.W(W)) u_shift (
        .a(op_a), .op(op), .res(shift_res), .out_bit(shift_c)
    );

    always_comb begin
        nxt_flags = '0;
        case (cls)
            CLS_ARITH: begin
                sel_res     = arith_res;
                nxt_flags.c = arith_c;
                nxt_flags.v = arith_v;
            end
            CLS_LOGIC: sel_res = logic_res;
            CLS_SHIFT: begin
                sel_res     = shift_res;
                nxt_flags.c = shift_c;
            end
            default:   sel_res = '0;
        endcase
        nxt_flags.z = (sel_res == '0);
        nxt_flags.n = sel_res[MSB];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            flags_q  <= '0;
        end else begin
            result_q <= sel_res;
            flags_q  <= nxt_flags;
        end
    end

    assign flag_z = flags_q.z;
    assign flag_n = flags_q.n;
    assign flag_c = flags_q.c;
    assign flag_v = flags_q.v;

endmodule

// File: rtl/alu_flagged_chk.sv
module alu_flagged_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [3:0]   func,
    input logic [W-1:0] result_q,
    input logic         flag_z,
    input logic         flag_n,
    input logic         flag_c,
    input logic         flag_v
);
    logic started_q;
    logic primed_q;

    always_ff @(posedge clk) begin
        started_q <= 1'b1;
        if (rst) primed_q <= 1'b0;
        else     primed_q <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        started_q && $past(rst) |-> (result_q == '0) && !flag_z && !flag_n && !flag_c && !flag_v); // R1

    AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
        primed_q && ($past(func) == 4'b0000) |->
            ({flag_c, result_q} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)}))); // R2

    AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (rst)
        primed_q && ($past(func) == 4'b0110) |->
            (result_q == $past(op_a) - $past(op_b)) && (flag_c == ($past(op_a) >= $past(op_b)))); // R3

    AST_ZERO_EXACT: assert property (@(posedge clk) disable iff (rst)
        primed_q |-> (flag_z == (result_q == '0))); // R6

    AST_NEG_TOP: assert property (@(posedge clk) disable iff (rst)
        primed_q |-> (flag_n == result_q[W-1])); // R6

    AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        primed_q && ($past(func) >= 4'b0010) && ($past(func) <= 4'b0101) |-> !flag_c && !flag_v); // R7

    AST_SHIFT_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        primed_q && ($past(func) >= 4'b1010) && ($past(func) <= 4'b1100) |-> !flag_v); // R8

    AST_ROTATE_LEFT: assert property (@(posedge clk) disable iff (rst)
        primed_q && ($past(func) == 4'b1101) |->
            (result_q == {$past(op_a[W-2:0]), $past(op_a[W-1])}) && (flag_c == $past(op_a[W-1])) && !flag_v); // R9

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        primed_q && ($past(func) == 4'b1111) |->
            (result_q == '0) && flag_z && !flag_n && !flag_c && !flag_v); // R10

endmodule

bind alu_flagged alu_flagged_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .func(func),
    .result_q(result_q), .flag_z(flag_z), .flag_n(flag_n),
    .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/alu_flagged_tb.sv
module alu_flagged_tb;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;
    localparam longint MASK = (64'd1 << W) - 1;
    localparam longint HALF = 64'd1 << (W - 1);

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] op_a, op_b;
    logic         carry_in;
    logic [3:0]   func;
    logic [W-1:0] result_q;
    logic         flag_z, flag_n, flag_c, flag_v;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    int unsigned seed = 32'h1234_5678;

    typedef struct {
        longint r;
        bit z, n, c, v;
        int f;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    alu_flagged #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
        .func(func), .result_q(result_q), .flag_z(flag_z), .flag_n(flag_n),
        .flag_c(flag_c), .flag_v(flag_v)
    );

    function automatic longint sgn(longint x);
        return (x >= HALF) ? x - (MASK + 1) : x;
    endfunction

    function automatic bit out_of_range(longint s);
        return (s > HALF - 1) || (s < -HALF);
    endfunction

    function automatic exp_t model(longint a, longint b, bit cin, int f);
        exp_t e;
        longint s;
        longint bor;
        e.c = 0; e.v = 0; e.f = f; e.r = 0;
        bor = cin ? 0 : 1;
        case (f)
            0:  begin s = a + b;       e.r = s & MASK; e.c = (s > MASK); e.v = out_of_range(sgn(a) + sgn(b)); end
            1:  begin s = a + b + cin; e.r = s & MASK; e.c = (s > MASK); e.v = out_of_range(sgn(a) + sgn(b) + cin); end
            2:  e.r = a & b;
            3:  e.r = a | b;
            4:  e.r = a ^ b;
            5:  e.r = MASK - a;
            6:  begin e.r = (a - b) & MASK; e.c = (a >= b); e.v = out_of_range(sgn(a) - sgn(b)); end
            7:  begin e.r = (a - b - bor) & MASK; e.c = (a >= b + bor); e.v = out_of_range(sgn(a) - sgn(b) - bor); end
            8:  begin e.r = (a + 1) & MASK; e.c = (a == MASK); e.v = out_of_range(sgn(a) + 1); end
            9:  begin e.r = (a - 1) & MASK; e.c = (a != 0); e.v = out_of_range(sgn(a) - 1); end
            10: begin e.r = (a * 2) & MASK; e.c = (a >= HALF); end
            11: begin e.r = a / 2; e.c = a[0]; end
            12: begin e.r = (a / 2) + (a & HALF); e.c = a[0]; end
            13: begin e.r = ((a * 2) & MASK) + (a / HALF); e.c = (a >= HALF); end
            14: begin e.r = (a / 2) + (a[0] ? HALF : 0); e.c = a[0]; end
            default: e.r = 0;
        endcase
        e.z = (e.r == 0);
        e.n = (e.r >= HALF);
        return e;
    endfunction

    function automatic string tag_of(int f);
        case (f)
            0, 1:          return "R2";
            6, 7:          return "R3";
            8, 9:          return "R4";
            2, 3, 4, 5:    return "R7";
            10, 11, 12:    return "R8";
            13, 14:        return "R9";
            default:       return "R10";
        endcase
    endfunction

    task automatic check(string req, string what, longint act, longint expv);
        compared++;
        if (act != expv) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic compare_pending();
        exp_t e;
        string t;
        bit arith;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        t = tag_of(e.f);
        arith = (e.f <= 1) || (e.f >= 6 && e.f <= 9);
        check(t, "result", longint'(result_q), e.r);
        check(t, "carry", longint'(flag_c), longint'(e.c));
        check(arith ? "R5" : t, "overflow", longint'(flag_v), longint'(e.v));
        check("R6", "zero", longint'(flag_z), longint'(e.z));
        check("R6", "negative", longint'(flag_n), longint'(e.n));
    endtask

    task automatic drive(longint a, longint b, bit cin, int f);
        @(negedge clk);
        compare_pending();
        op_a = W'(a); op_b = W'(b); carry_in = cin; func = 4'(f);
        exp_q.push_back(model(a, b, cin, f));
    endtask

    function automatic int unsigned next_rand();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        op_a = '1; op_b = 8'h01; carry_in = 1'b1; func = 4'b0000;
        repeat (3) @(negedge clk);
        // R1: reset clears everything even with live operands
        check("R1", "reset result", longint'(result_q), 0);
        check("R1", "reset z", longint'(flag_z), 0);
        check("R1", "reset n", longint'(flag_n), 0);
        check("R1", "reset c", longint'(flag_c), 0);
        check("R1", "reset v", longint'(flag_v), 0);
        rst = 1'b0;

        drive(5, 3, 0, 6);           // R3 worked subtraction example: 2, C=1
        drive(8'hF0, 8'h0F, 0, 2);   // R7 AND of complementary halves gives zero
        drive(8'h7F, 1, 0, 0);       // R5 signed overflow on add
        drive(8'hFF, 1, 0, 0);       // R2 carry out with zero result
        drive(8'hFF, 0, 1, 1);       // R2 carry-in ripples through
        drive(8'h80, 1, 1, 6);       // R5 signed overflow on subtract
        drive(3, 5, 1, 6);           // R3 borrow clears carry
        drive(5, 5, 0, 7);           // R3 SBC with borrow in
        drive(5, 5, 1, 7);           // R3 SBC without borrow in
        drive(8'hFF, 0, 0, 8);       // R4 increment wraps
        drive(8'h7F, 0, 0, 8);       // R4/R5 increment overflow
        drive(0, 0, 0, 9);           // R4 decrement of zero
        drive(8'h80, 0, 0, 9);       // R4/R5 decrement overflow
        drive(8'h81, 0, 0, 10);      // R8 left shift out bit
        drive(8'h81, 0, 0, 12);      // R8 arithmetic right keeps sign
        drive(8'h81, 0, 0, 13);      // R9 rotate left wraps
        drive(8'h01, 0, 0, 14);      // R9 rotate right wraps
        drive(8'hAA, 8'h55, 1, 15);  // R10 unused code
        drive(8'h00, 0, 0, 5);       // R7 NOT gives all ones

        for (int f = 0; f < 16; f++) begin
            for (int k = 0; k < 40; k++) begin
                int unsigned r1, r2;
                r1 = next_rand();
                r2 = next_rand();
                drive(longint'(r1 & 32'hFF), longint'(r2 & 32'hFF), r1[31], f);
            end
        end

        @(negedge clk);
        compare_pending();
        finish_run();
    end

endmodule